// File: doc/BRIEF.md
# Six-Step Bridge Gate Sequencer

This block produces the gate enables for a three-phase bridge made of six switches, three on the top rail and three on the bottom rail. A step pulse, arriving once every 60 electrical degrees of the wanted output frequency, moves the sequencer to its next phase. At any moment three switches are enabled: two in one row and one in the other. Each switch stays on for three consecutive phases, and the switches are staggered one phase apart.

At every step the sequencer fires a commutation pulse at the row that held two switches on just before the step. This is the row in which a switch must now be turned off. The pulses therefore fall alternately on the top row and the bottom row. After each step a blanking window holds every bridge gate low, so the row being commutated cannot be re-gated while its turn-off circuit recovers. A trip input from the protection logic overrides everything: it forces all six gates on and silences both commutation outputs.

The phase is held in three flip-flops that run through six of their eight codes. Exactly one bit changes per step. The two unused codes fall back to the start code on the next clock. The pulse width and the blanking length are parameters counted in clock cycles.

Top module: `sixstep_gate_seq`

## Requirements
- R1: After reset the block is in phase 0: gateTop = 3'b101, gateBot = 3'b010, blankOut = 0, and both commutation outputs are low.
- R2: Only a rising edge of stepIn advances the phase, by exactly one. A stepIn held high for many cycles advances it once. The advance shows on the outputs in the cycle after the clock edge that first samples stepIn high.
- R3: Six advances bring the outputs back to the phase-0 pattern. The internal code changes in exactly one bit per advance, and either of the two unused codes is replaced by the start code at the next clock.
- R4: Outside blanking and trip, in phase k (0..5), gateTop[i] is 1 exactly when (k - 2i) mod 6 is 0, 1 or 2, and gateBot[i] is the inverse of gateTop[i]. Bit i is bridge leg i.
- R5: Outside blanking and trip, exactly three gates are on. The top row holds two of them in even phases and the bottom row holds two in odd phases.
- R6: Between two consecutive phases exactly one gate turns off and one turns on. The gate turning off is in the row that held two gates on.
- R7: Each advance starts a commutation pulse that lasts COMM_CYC cycles. It goes on commTopPulse when the phase before the step was even, and on commBotPulse when it was odd. A new advance ends any pulse still running and starts the new one.
- R8: Each advance raises blankOut for BLANK_CYC cycles. While blankOut is high and tripIn is low, all six gates are low.
- R9: A step that arrives during blanking still advances the phase and restarts the blanking window at its full length.
- R10: While tripIn is high, all six gates are high and both commutation outputs are low, whatever the phase or blanking state. The effect is combinational, not registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepIn | input | 1 | Step request; its rising edge advances the phase by 60 degrees |
| tripIn | input | 1 | Protection override: all gates on, commutation off |
| gateTop | output | 3 | Top-row gate enables, bit i = leg i |
| gateBot | output | 3 | Bottom-row gate enables, bit i = leg i |
| commTopPulse | output | 1 | Commutation pulse for the top row |
| commBotPulse | output | 1 | Commutation pulse for the bottom row |
| blankOut | output | 1 | High while the post-step blanking window runs |

## Verification
The hardest states to reach from the ports are the overlaps: a step that lands inside a running blanking window, and a trip that arrives while a commutation pulse is live and the gates are still blanked. The stimulus fires steps two or three cycles apart with a blanking length longer than that gap, then raises the trip one cycle after a step edge. The two unused phase codes cannot be reached from the ports at all, so their recovery rests on the embedded properties alone.

// File: rtl/sixstep_pkg.sv
`timescale 1ns/1ps
package sixstep_pkg;

  // 3-bit phase code; the six legal codes form a shift-and-invert ring
  typedef logic [2:0] phaseCode_t;

  localparam phaseCode_t PHASE_START = 3'b000;

  // Strobes from control to datapath, valid in the cycle of a step edge
  typedef struct packed {
    logic advance;  // phase moves at this clock edge
    logic commTop;  // row with two devices on before the step is the top row
  } seqStrobe_t;

  function automatic logic codeLegal(phaseCode_t code);
    return (code != 3'b010) && (code != 3'b101);
  endfunction

endpackage

// File: rtl/sixstep_oneshot.sv
`timescale 1ns/1ps
module sixstep_oneshot #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic fire,
  output logic active
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain <= '0;
    end else if (fire) begin
      remain <= CW'(LEN);
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign active = (remain != '0);

endmodule

// File: rtl/sixstep_ctrl.sv
`timescale 1ns/1ps
module sixstep_ctrl
  import sixstep_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stepIn,
  output phaseCode_t phase,
  output seqStrobe_t strobe
);
  logic       stepPrev;
  logic       stepEdge;
  logic       legal;
  phaseCode_t phaseNext;

  assign stepEdge  = stepIn & ~stepPrev;
  assign legal     = codeLegal(phase);
  assign phaseNext = {phase[1:0], ~phase[2]};

  always_comb begin
    strobe.advance = stepEdge & legal;
    // even phases (code parity 0) have two devices on in the top row
    strobe.commTop = ~^phase;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepPrev <= 1'b0;
      phase    <= PHASE_START;
    end else begin
      stepPrev <= stepIn;
      if (!legal) begin
        phase <= PHASE_START;
      end else if (stepEdge) begin
        phase <= phaseNext;
      end
    end
  end

  AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> ($countones(phase ^ $past(phase)) == 1)); // R3

  AST_HOLD_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    (!stepEdge && legal) |=> $stable(phase)); // R2

  AST_ILLEGAL_RECOVER: assert property (@(posedge clk) disable iff (!rstN)
    !legal |=> (phase == PHASE_START)); // R3

endmodule

// File: rtl/sixstep_dp.sv
`timescale 1ns/1ps
module sixstep_dp
  import sixstep_pkg::*;
#(
  parameter int BLANK_CYC = 9000,
  parameter int COMM_CYC  = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tripIn,
  input  phaseCode_t phase,
  input  seqStrobe_t strobe,
  output logic [2:0] gateTop,
  output logic [2:0] gateBot,
  output logic       commTopPulse,
  output logic       commBotPulse,
  output logic       blankOut
);
  logic       commActive;
  logic       commRowTop;
  logic [2:0] topDecode;

  sixstep_oneshot #(.LEN(BLANK_CYC)) u_blank (
    .clk    (clk),
    .rstN   (rstN),
    .fire   (strobe.advance),
    .active (blankOut)
  );

  sixstep_oneshot #(.LEN(COMM_CYC)) u_comm (
    .clk    (clk),
    .rstN   (rstN),
    .fire   (strobe.advance),
    .active (commActive)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      commRowTop <= 1'b0;
    end else if (strobe.advance) begin
      commRowTop <= strobe.commTop;
    end
  end

  // leg i top device conducts over three consecutive phases
  assign topDecode = {~phase[0], phase[1], ~phase[2]};

  always_comb begin
    if (tripIn) begin
      gateTop = '1;
      gateBot = '1;
    end else if (blankOut) begin
      gateTop = '0;
      gateBot = '0;
    end else begin
      gateTop = topDecode;
      gateBot = ~topDecode;
    end
  end

  assign commTopPulse = commActive & commRowTop  & ~tripIn;
  assign commBotPulse = commActive & ~commRowTop & ~tripIn;

  AST_BLANK_AFTER_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> blankOut); // R8

  AST_COMM_AFTER_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> commActive); // R7

  AST_COMM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({commTopPulse, commBotPulse})); // R7

  AST_THREE_ON: assert property (@(posedge clk) disable iff (!rstN)
    (!blankOut && !tripIn) |-> ($countones({gateTop, gateBot}) == 3)); // R5

endmodule

// File: rtl/sixstep_gate_seq.sv
`timescale 1ns/1ps
module sixstep_gate_seq
  import sixstep_pkg::*;
#(
  parameter int BLANK_CYC = 9000,  // ~90 us at a 100 MHz clock
  parameter int COMM_CYC  = 1000   // ~10 us at a 100 MHz clock
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stepIn,
  input  logic       tripIn,
  output logic [2:0] gateTop,
  output logic [2:0] gateBot,
  output logic       commTopPulse,
  output logic       commBotPulse,
  output logic       blankOut
);
  phaseCode_t phase;
  seqStrobe_t strobe;

  sixstep_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .stepIn (stepIn),
    .phase  (phase),
    .strobe (strobe)
  );

  sixstep_dp #(.BLANK_CYC(BLANK_CYC), .COMM_CYC(COMM_CYC)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .tripIn       (tripIn),
    .phase        (phase),
    .strobe       (strobe),
    .gateTop      (gateTop),
    .gateBot      (gateBot),
    .commTopPulse (commTopPulse),
    .commBotPulse (commBotPulse),
    .blankOut     (blankOut)
  );

endmodule

// File: tb/sixstep_gate_seq_bench.sv
`timescale 1ns/1ps
module sixstep_gate_seq_bench;
  localparam int BLANK = 6;
  localparam int COMM  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stepIn = 1'b0;
  logic tripIn = 1'b0;
  logic [2:0] gateTop, gateBot;
  logic commTopPulse, commBotPulse, blankOut;

  sixstep_gate_seq #(.BLANK_CYC(BLANK), .COMM_CYC(COMM)) u_sixstep_gate_seq (
    .clk(clk), .rstN(rstN), .stepIn(stepIn), .tripIn(tripIn),
    .gateTop(gateTop), .gateBot(gateBot),
    .commTopPulse(commTopPulse), .commBotPulse(commBotPulse), .blankOut(blankOut)
  );

  always #2 clk = ~clk;

  int  checks = 0;
  int  errors = 0;
  int  cycles = 0;
  bit  done = 0;

  // behavioural reference state
  int  mK = 0, mBlank = 0, mComm = 0, stepsSince = 0;
  bit  mRowTop = 0, mPrev = 0, prevValid = 0;
  logic [5:0] prevVec = '0;

  function automatic logic [2:0] topPat(int k);
    logic [2:0] p;
    for (int i = 0; i < 3; i++) p[i] = (((k - 2*i + 12) % 6) < 3);
    return p;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mK = 0; mBlank = 0; mComm = 0; mRowTop = 0; mPrev = 0;
    end else begin
      if (stepIn && !mPrev) begin
        mRowTop = (mK % 2 == 0);
        mK = (mK + 1) % 6;
        mBlank = BLANK;
        mComm = COMM;
        stepsSince++;
      end else begin
        if (mBlank > 0) mBlank--;
        if (mComm > 0) mComm--;
      end
      mPrev = stepIn;
    end
    if (cycles > 100000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      finishRun();
    end
  end

  // per-cycle comparison against the reference, 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (rstN && !done) begin
      logic [2:0] eTop, eBot;
      bit eCt, eCb, eBl;
      eBl = (mBlank > 0);
      if (tripIn) begin
        eTop = 3'b111; eBot = 3'b111;
      end else if (eBl) begin
        eTop = 3'b000; eBot = 3'b000;
      end else begin
        eTop = topPat(mK); eBot = ~topPat(mK);
      end
      eCt = !tripIn && (mComm > 0) && mRowTop;
      eCb = !tripIn && (mComm > 0) && !mRowTop;
      check(gateTop == eTop, tripIn ? "R10" : "R4", "gateTop", gateTop, eTop);
      check(gateBot == eBot, tripIn ? "R10" : "R4", "gateBot", gateBot, eBot);
      check(blankOut == eBl, "R8/R9", "blankOut", blankOut, eBl);
      check(commTopPulse == eCt, tripIn ? "R10" : "R7", "commTopPulse", commTopPulse, eCt);
      check(commBotPulse == eCb, tripIn ? "R10" : "R7", "commBotPulse", commBotPulse, eCb);
      if (!blankOut && !tripIn) begin
        logic [5:0] cur;
        int nTop;
        cur = {gateTop, gateBot};
        nTop = $countones(gateTop);
        check($countones(cur) == 3, "R5", "gates on", $countones(cur), 3);
        check(nTop == ((mK % 2 == 0) ? 2 : 1), "R5", "top row count", nTop, (mK % 2 == 0) ? 2 : 1);
        if (prevValid && stepsSince == 1) begin
          logic [5:0] offBits;
          bit offTop, prevTopTwo;
          offBits = prevVec & ~cur;
          offTop = (offBits[5:3] != 3'b000);
          prevTopTwo = ($countones(prevVec[5:3]) == 2);
          check($countones(prevVec ^ cur) == 2, "R6", "changed gates", $countones(prevVec ^ cur), 2);
          check($countones(offBits) == 1, "R6", "gates turned off", $countones(offBits), 1);
          check(offTop == prevTopTwo, "R6", "row of turn-off", offTop, prevTopTwo);
        end
        prevVec = cur;
        prevValid = 1;
        stepsSince = 0;
      end
    end
  end

  task automatic stepOnly();
    @(negedge clk); stepIn = 1'b1;
    @(negedge clk); stepIn = 1'b0;
  endtask

  task automatic stepGap(int gap);
    stepOnly();
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(gateTop == 3'b101, "R1", "reset gateTop", gateTop, 3'b101);
    check(gateBot == 3'b010, "R1", "reset gateBot", gateBot, 3'b010);
    check(blankOut == 1'b0, "R1", "reset blankOut", blankOut, 0);
    check({commTopPulse, commBotPulse} == 2'b00, "R1", "reset comm", {commTopPulse, commBotPulse}, 0);

    // first step from even phase 0: top-row commutation, blanking on
    stepOnly();
    check(commTopPulse == 1'b1, "R7", "top pulse after phase 0", commTopPulse, 1);
    check(blankOut == 1'b1, "R8", "blank after step", blankOut, 1);
    repeat (10) @(negedge clk);
    stepOnly();
    check(commBotPulse == 1'b1, "R7", "bottom pulse after phase 1", commBotPulse, 1);
    repeat (10) @(negedge clk);
    for (int j = 0; j < 4; j++) stepGap(10);
    // R3 six steps return to the phase-0 pattern
    check(gateTop == 3'b101, "R3", "gateTop after six steps", gateTop, 3'b101);
    check(gateBot == 3'b010, "R3", "gateBot after six steps", gateBot, 3'b010);

    // R2 held step advances once
    @(negedge clk); stepIn = 1'b1;
    repeat (20) @(negedge clk);
    stepIn = 1'b0;
    repeat (10) @(negedge clk);
    check(gateTop == 3'b001, "R2", "gateTop after held step", gateTop, 3'b001);
    check(gateBot == 3'b110, "R2", "gateBot after held step", gateBot, 3'b110);

    // R9 step inside blanking restarts the window
    stepGap(2);
    stepOnly();
    repeat (4) @(negedge clk);
    check(blankOut == 1'b1, "R9", "blank restarted", blankOut, 1);
    repeat (10) @(negedge clk);
    for (int j = 0; j < 8; j++) stepGap(1);
    repeat (10) @(negedge clk);

    // R10 trip during live pulse and blanking
    stepOnly();
    tripIn = 1'b1;
    #1;
    check(gateTop == 3'b111 && gateBot == 3'b111, "R10", "gates under trip",
          {gateTop, gateBot}, 6'h3f);
    check({commTopPulse, commBotPulse} == 2'b00, "R10", "comm under trip",
          {commTopPulse, commBotPulse}, 0);
    stepGap(3);
    repeat (8) @(negedge clk);
    tripIn = 1'b0;
    repeat (10) @(negedge clk);

    // mixed spacing
    for (int j = 0; j < 30; j++) stepGap((j * 7) % 11 + 1);
    repeat (12) @(negedge clk);
    finishRun();
  end

endmodule